// File: doc/BRIEF.md
# Input Change Capture Latches

This block watches a bank of digital inputs on behalf of a host processor and records which of them have changed level since the host last looked. Each input passes through a synchronizer and is then compared against a stored reference level, the "old" bank. When the synchronized level differs from the reference, the per-input latch in the "new" bank captures the changed level and freezes. The host sees an active-low change indication and a change flag in a status byte. It then reads the status byte, the new bank and the old bank, in whatever order it needs.

Reading the new bank moves each latch into the old bank and re-arms the latch for the next change. Reading the old bank has no side effects. The upper inputs can be masked. A masked input never raises the indication, and its bits in both banks follow the live level.

Reads use single-cycle strobes. The selected register comes back on `rd_data_o` one cycle later, with `rd_valid_o` high for that one cycle. There is no back-pressure. The host must capture the data in the cycle `rd_valid_o` is high, and it may issue a new strobe on any cycle.

Top module: `chg_capture_top`

## Requirements
- R1: An armed, unmasked latch captures the synchronized level as soon as it differs from the old-bank bit, then holds that value, ignoring further input changes, until the next new-bank read.
- R2: A new-bank read returns the new bank as it was before the read. On the same edge, each old-bank bit is loaded from its latch and the latch is re-armed, so a level that still differs is captured again one cycle later.
- R3: An old-bank read returns the old bank and changes no latch, no old-bank bit, no status flag and not `chg_n_o`.
- R4: `mask_i[k]` = 1 masks input index N_IN-N_MASK+k (with defaults, mask bits 0..3 map to inputs 4..7). A masked input never raises `chg_n_o` low, never sets the status flag and never pulses `chg_evt_o`.
- R5: While an input is masked, its bit in both the old and new banks equals its synchronized live level, one cycle behind the synchronizer output.
- R6: A capture on any unmasked input sets status bit 7 (the most significant bit, N_IN-1) and drives `chg_n_o` low on the capturing edge. `chg_evt_o` pulses high for exactly one cycle on that edge, even when several inputs capture together.
- R7: A status read returns a byte with bit 7 = change flag and all other bits 0. It clears the flag and returns `chg_n_o` high, unless a new capture happens on the same edge, in which case the flag stays set.
- R8: During reset (synchronous, active-low `rst_n`), the synchronizer, the old bank and the new bank all load the present input levels, and every latch is armed. After reset the status flag is 0, `chg_n_o` is 1 and `chg_evt_o` is 0.
- R9: An input edge applied before clock edge E0 is captured on edge E0+2, through a two-stage synchronizer.
- R10: A capture arriving on the same edge as a new-bank read is kept. The read returns the pre-capture value, the latch holds the new level, and the next new-bank read returns it.
- R11: If several strobes are high together, only one is served, with priority new bank, then old bank, then status. Only the served read has side effects. `rd_valid_o` is high exactly one cycle after any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | N_IN | Asynchronous monitored inputs |
| mask_i | input | N_MASK | Mask bits for the upper N_MASK inputs, 1 = masked |
| rd_old_i | input | 1 | Strobe: read the old bank |
| rd_new_i | input | 1 | Strobe: read the new bank and re-arm |
| rd_status_i | input | 1 | Strobe: read and clear the status byte |
| rd_data_o | output | N_IN | Read data, valid when rd_valid_o is high |
| rd_valid_o | output | 1 | High one cycle after a served strobe |
| chg_n_o | output | 1 | Active-low change indication |
| chg_evt_o | output | 1 | One-cycle pulse on each capturing edge |

## Verification
An input change is due in the latches, the status flag and `chg_n_o` three rising edges after it is driven: two synchronizer edges and one capture edge. The `chg_evt_o` pulse is counted at the rising edge that follows the capture edge. Read data is due one edge after the strobe. A re-capture after a new-bank read lands one edge after that read. The bench drives on falling edges, waits exactly these counts of rising edges, and samples on the next falling edge. The same-edge case of R10 is built by raising the new-bank strobe two edges after the input change, so that the read and the capture share the third edge.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_OLD  = 2'd1,
    SEL_NEW  = 2'd2,
    SEL_STAT = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  // reset loads the present levels so no spurious change follows reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= d_i;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/chg_cell.sv
module chg_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,
  input  logic mask_i,
  input  logic rd_new_i,
  output logic old_o,
  output logic new_o,
  output logic hit_o
);
  logic old_q, new_q, armed_q;
  logic hit;

  assign hit = !mask_i && armed_q && (live_i != old_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      old_q   <= live_i;
      new_q   <= live_i;
      armed_q <= 1'b1;
    end else if (mask_i) begin
      old_q   <= live_i;
      new_q   <= live_i;
      armed_q <= 1'b1;
    end else begin
      if (rd_new_i) old_q <= new_q;
      if (hit) begin
        new_q   <= live_i;
        armed_q <= 1'b0;
      end else if (rd_new_i) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign old_o = old_q;
  assign new_o = new_q;
  assign hit_o = hit;

  // an armed latch always mirrors the reference level
  assert_armed_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (new_q == old_q));
  // a frozen latch holds until read or masked
  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_i && !armed_q && !rd_new_i) |=> $stable(new_q));
  // masked bits follow the live level in both banks
  assert_mask_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |=> (new_q == $past(live_i)) && (old_q == $past(live_i)));
  // capture coinciding with a read is kept for the next read
  assert_same_edge_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rd_new_i) |=> (!armed_q && new_q == $past(live_i)));
endmodule

// File: rtl/chg_bank.sv
module chg_bank #(
  parameter int N_IN   = 8,
  parameter int N_MASK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   live_i,
  input  logic [N_MASK-1:0] mask_i,
  input  logic              rd_new_i,
  output logic [N_IN-1:0]   old_o,
  output logic [N_IN-1:0]   new_o,
  output logic              any_hit_o
);
  localparam int LO = N_IN - N_MASK;

  logic [N_IN-1:0] mask_full;
  logic [N_IN-1:0] hit_vec;

  assign mask_full = {mask_i, {LO{1'b0}}};

  for (genvar i = 0; i < N_IN; i++) begin : g_cell
    chg_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .live_i   (live_i[i]),
      .mask_i   (mask_full[i]),
      .rd_new_i (rd_new_i),
      .old_o    (old_o[i]),
      .new_o    (new_o[i]),
      .hit_o    (hit_vec[i])
    );
  end

  assign any_hit_o = |hit_vec;

  // masked inputs never contribute a hit
  assert_mask_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & mask_full) == '0);
endmodule

// File: rtl/chg_status.sv
module chg_status #(
  parameter int W       = 8,
  parameter int CHG_BIT = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_i,
  input  logic         clr_i,
  output logic [W-1:0] status_o,
  output logic         chg_n_o,
  output logic         evt_o
);
  logic flag_q, evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr_i);
      evt_q  <= set_i;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[CHG_BIT] = flag_q;
  end

  assign chg_n_o = ~flag_q;
  assign evt_o   = evt_q;

  assert_set_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (!chg_n_o && evt_o));
  assert_clear_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> chg_n_o);
endmodule

// File: rtl/chg_capture_top.sv
module chg_capture_top #(
  parameter int N_IN        = 8,
  parameter int N_MASK      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   pins_i,
  input  logic [N_MASK-1:0] mask_i,
  input  logic              rd_old_i,
  input  logic              rd_new_i,
  input  logic              rd_status_i,
  output logic [N_IN-1:0]   rd_data_o,
  output logic              rd_valid_o,
  output logic              chg_n_o,
  output logic              chg_evt_o
);
  import chg_pkg::*;

  localparam int CHG_BIT = N_IN - 1;

  logic [N_IN-1:0] live_w, old_w, new_w, stat_w;
  logic            any_hit_w;
  rd_sel_e         sel;
  logic [N_IN-1:0] rd_data_q;
  logic            rd_valid_q;

  always_comb begin
    if (rd_new_i)         sel = SEL_NEW;
    else if (rd_old_i)    sel = SEL_OLD;
    else if (rd_status_i) sel = SEL_STAT;
    else                  sel = SEL_NONE;
  end

  chg_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pins_i),
    .q_o   (live_w)
  );

  chg_bank #(.N_IN(N_IN), .N_MASK(N_MASK)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_i    (live_w),
    .mask_i    (mask_i),
    .rd_new_i  (sel == SEL_NEW),
    .old_o     (old_w),
    .new_o     (new_w),
    .any_hit_o (any_hit_w)
  );

  chg_status #(.W(N_IN), .CHG_BIT(CHG_BIT)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (any_hit_w),
    .clr_i    (sel == SEL_STAT),
    .status_o (stat_w),
    .chg_n_o  (chg_n_o),
    .evt_o    (chg_evt_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= (sel != SEL_NONE);
      case (sel)
        SEL_NEW:  rd_data_q <= new_w;
        SEL_OLD:  rd_data_q <= old_w;
        SEL_STAT: rd_data_q <= stat_w;
        default:  rd_data_q <= rd_data_q;
      endcase
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;

  assert_valid_follows_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_old_i || rd_new_i || rd_status_i) |=> rd_valid_o);
  assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_old_i || rd_new_i || rd_status_i) |=> !rd_valid_o);
  assert_new_read_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_new_i |=> (rd_data_o == $past(new_w)));
endmodule

// File: tb/tb_chg_capture_top.sv
module tb_chg_capture_top;
  localparam int N  = 8;
  localparam int NM = 4;
  localparam int LO = N - NM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic [NM-1:0] mask = '0;
  logic rd_old = 1'b0, rd_new = 1'b0, rd_stat = 1'b0;
  logic [N-1:0] rd_data;
  logic rd_valid, chg_n, chg_evt;

  int checks = 0, errors = 0, evt_cnt = 0, exp_evt = 0;
  logic [N-1:0] e_old, e_new, e_cap;
  logic e_stat;

  always #4 clk = ~clk;

  chg_capture_top dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .mask_i(mask),
    .rd_old_i(rd_old), .rd_new_i(rd_new), .rd_status_i(rd_stat),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .chg_n_o(chg_n), .chg_evt_o(chg_evt)
  );

  always @(posedge clk) if (rst_n && chg_evt) evt_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit is_masked(input int i);
    return (i >= LO) && mask[i-LO];
  endfunction

  // transaction-level expectation: applies the capture rule to present pins
  task automatic model_capture();
    bit any = 0;
    for (int i = 0; i < N; i++) begin
      if (is_masked(i)) begin
        e_old[i] = pins[i]; e_new[i] = pins[i]; e_cap[i] = 1'b0;
      end else if (!e_cap[i] && pins[i] != e_old[i]) begin
        e_new[i] = pins[i]; e_cap[i] = 1'b1; any = 1;
      end
    end
    if (any) begin e_stat = 1'b1; exp_evt++; end
  endtask

  task automatic check_state(input string tag);
    tick(1);
    check({"R6 evt ", tag}, evt_cnt, exp_evt);
    check({"R6/R7 chg_n ", tag}, chg_n, !e_stat);
  endtask

  // R9: capture due three edges after drive
  task automatic set_pins(input logic [N-1:0] v, input string tag);
    pins = v;
    tick(3);
    model_capture();
    check_state(tag);
  endtask

  task automatic do_read(input bit o, input bit n, input bit s, input string req);
    logic [N-1:0] exp;
    rd_old = o; rd_new = n; rd_stat = s;
    @(posedge clk); @(negedge clk);
    rd_old = 0; rd_new = 0; rd_stat = 0;
    if (n) begin
      exp = e_new;
      for (int i = 0; i < N; i++) if (!is_masked(i)) begin e_old[i] = e_new[i]; e_cap[i] = 1'b0; end
    end else if (o) exp = e_old;
    else begin
      exp = {e_stat, {(N-1){1'b0}}};
      e_stat = 1'b0;
    end
    check({req, " data"}, rd_data, exp);
    check("R11 valid", rd_valid, 1);
    tick(1);
    model_capture();
    check_state(req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    pins = 8'hA5;
    tick(4);
    rst_n = 1'b1;
    e_old = 8'hA5; e_new = 8'hA5; e_cap = '0; e_stat = 0;
    tick(2);
    // R8: reset state
    check("R8 chg_n", chg_n, 1);
    check("R8 evt", evt_cnt, 0);
    check("R11 idle valid", rd_valid, 0);
    do_read(1, 0, 0, "R8 old");
    do_read(0, 0, 1, "R8 status");
    do_read(0, 1, 0, "R8 new");

    // R1/R2/R6/R7/R9: single-bit sweep on every input
    for (int i = 0; i < N; i++) begin
      set_pins(pins ^ (8'h01 << i), "R9 sweep");
      do_read(1, 0, 0, "R3 old before");
      do_read(0, 0, 1, "R7 status");
      do_read(0, 1, 0, "R2 new");
      do_read(1, 0, 0, "R2 old after");
    end

    // R1: latch holds first change even if input returns
    v = pins;
    set_pins(v ^ 8'h04, "R1 change");
    set_pins(v, "R1 return");
    do_read(1, 0, 0, "R3 old no effect");
    do_read(1, 0, 0, "R3 old again");
    do_read(0, 1, 0, "R1 held");
    do_read(0, 0, 1, "R7 status recapture");
    do_read(0, 1, 0, "R2 recaptured");
    do_read(0, 0, 1, "R7 clear");

    // R4/R5: sweep every mask pattern
    for (int m = 0; m < (1 << NM); m++) begin
      mask = m[NM-1:0];
      tick(1);
      model_capture();
      set_pins(pins ^ 8'hF0, "R4 mask");
      do_read(1, 0, 0, "R5 old");
      do_read(0, 1, 0, "R5 new");
      do_read(0, 0, 1, "R4 status");
      set_pins(pins ^ 8'h30, "R5 live");
      do_read(0, 1, 0, "R5 new live");
      do_read(0, 0, 1, "R4 status2");
    end
    mask = '0;
    tick(1);
    model_capture();
    do_read(0, 1, 0, "R2 cleanup");
    do_read(0, 0, 1, "R7 cleanup");

    // R10: capture and new read on the same edge
    pins = pins ^ 8'h01;
    tick(2);
    rd_new = 1;
    @(posedge clk); @(negedge clk);
    rd_new = 0;
    check("R10 pre-capture data", rd_data, e_new);
    for (int i = 0; i < N; i++) e_old[i] = e_new[i];
    model_capture();
    check_state("R10");
    do_read(0, 1, 0, "R10 kept");

    // R11: priority when strobes collide
    set_pins(pins ^ 8'h02, "R11 setup");
    do_read(0, 1, 1, "R11 new over status");
    do_read(1, 0, 1, "R11 old over status");
    do_read(0, 0, 1, "R11 status");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule